// File: doc/BRIEF.md
# Reservation Monitor for Load-Locked / Store-Conditional

This block keeps the atomic-update reservations of several processor contexts that share one memory. Each context owns a single reservation: a block address and a valid flag. A locked load from a context arms that context's reservation. A later store-conditional from the same context is judged against it. The judgement decides whether the store may go to memory and which result code goes back to the context.

Every store that does reach memory breaks reservations on its block in all contexts, including the issuer's. This covers plain stores, successful store-conditionals and uncacheable store-conditionals. Matching is done on 16-byte blocks. A per-context counter tracks consecutive cacheable store-conditional failures and raises a one-cycle warning pulse each time the count reaches a multiple of a configurable period.

The monitor accepts at most one request per cycle. Its outputs are registered and appear one cycle after the request. It holds no data: the memory write itself happens elsewhere, gated by `mem_wr_en`.

Top module: `resv_monitor`

## Requirements
- R1: After reset every reservation is invalid, every failure count is zero, and `sc_valid`, `mem_wr_en` and `fail_warn` are low. A store-conditional issued straight after reset therefore fails.
- R2: A locked load (`req_kind` = 1) arms the issuing context's reservation with the request address. A cacheable store-conditional (`req_kind` = 3) from that context to the same block then returns result 1 (pass) and raises `mem_wr_en`.
- R3: Address matching ignores bits 3..0 and compares all higher bits. Addresses differing in any bit at position 4 or above, including the top bit, do not match.
- R4: A cacheable store-conditional without a matching valid reservation returns result 0 (fail) and leaves `mem_wr_en` low. It also invalidates the issuing context's reservation.
- R5: An uncacheable store-conditional (`req_uncached` = 1) skips the reservation check and returns result 2. It raises `mem_wr_en`, sets the issuer's failure count to zero, and invalidates matching reservations like any committed store.
- R6: A plain store (`req_kind` = 2) and a passing store-conditional invalidate the reservation of every context whose block matches, the issuer included.
- R7: A store to a different block leaves existing reservations intact.
- R8: Plain loads (`req_kind` = 0) never change reservation state and produce neither `sc_valid` nor `mem_wr_en`.
- R9: A failing cacheable store-conditional adds one to the issuer's count on `fail_count`. A passing one sets that count to zero.
- R10: `fail_warn[c]` pulses for one cycle, aligned with the store-conditional result, each time context c's failure count reaches a nonzero multiple of `WARN_PERIOD`.
- R11: `sc_valid`, `sc_result` and `mem_wr_en` are registered and refer to the request accepted one cycle earlier. `sc_valid` is high only for store-conditionals, and `mem_wr_en` is high for plain stores and for store-conditionals that return 1 or 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_ctx | input | $clog2(N_CTX) | Issuing context |
| req_addr | input | ADDR_W | Physical address |
| req_kind | input | 2 | 0 load, 1 locked load, 2 store, 3 store-conditional |
| req_uncached | input | 1 | Request targets uncacheable space |
| sc_valid | output | 1 | `sc_result` is valid this cycle |
| sc_result | output | 2 | 0 fail, 1 pass, 2 uncacheable bypass |
| mem_wr_en | output | 1 | Forward the previous cycle's store to memory |
| fail_warn | output | N_CTX | Per-context failure-period pulse |
| fail_count | output | N_CTX*CNT_W | Per-context consecutive failure counts, context c in bits c*CNT_W upward |

## Verification
The bench builds the block with four contexts and 64-bit addresses, so cross-context invalidation and top-bit address comparison are exercised at full width. `CNT_W` is set to 16, and `WARN_PERIOD` is reduced to 3 so that a warning pulse is reached within a handful of failures. With this period the bench can also show that the pulse is absent on the failures before it and that a pass restarts the period.

// File: rtl/resv_pkg.sv
// Shared encodings for the reservation monitor.
// Assumes a 2-bit request kind and a 2-bit store-conditional result.
package resv_pkg;

    typedef enum logic [1:0] {
        REQ_LOAD       = 2'd0,
        REQ_LOCK_LOAD  = 2'd1,
        REQ_STORE      = 2'd2,
        REQ_COND_STORE = 2'd3
    } req_kind_e;

    localparam logic [1:0] SC_FAIL   = 2'd0;
    localparam logic [1:0] SC_PASS   = 2'd1;
    localparam logic [1:0] SC_BYPASS = 2'd2;

    // log2 of the reservation match granule in bytes
    localparam int BLK_SHIFT = 4;

endpackage

// File: rtl/resv_slot.sv
// One context's reservation register: a block address and a valid flag.
// Assumes set_i and clr_i are never both relevant in one cycle; set wins.
// The block address is the request address with the granule offset removed.
module resv_slot #(
    parameter int BLK_W = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic             clr_i,
    input  logic [BLK_W-1:0] blk_i,
    output logic             valid_o,
    output logic             match_o
);

    logic [BLK_W-1:0] resv_blk;

    // Arm on a locked load, drop on an invalidation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o  <= 1'b0;
            resv_blk <= '0;
        end else if (set_i) begin
            valid_o  <= 1'b1;
            resv_blk <= blk_i;
        end else if (clr_i) begin
            valid_o  <= 1'b0;
        end
    end

    // Compare the stored block with the block on the request bus.
    always_comb match_o = (resv_blk == blk_i);

    // R8
    only_armed_by_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !set_i |=> !$rose(valid_o));

    // R6
    clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !valid_o);

endmodule

// File: rtl/fail_tracker.sv
// Consecutive store-conditional failure counter for one context.
// A phase counter running modulo WARN_PERIOD yields the warning pulse
// without a divider. Assumes clr_i and inc_i are never both set.
module fail_tracker #(
    parameter int CNT_W       = 32,
    parameter int WARN_PERIOD = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             warn_o
);

    localparam int PH_W = (WARN_PERIOD > 1) ? $clog2(WARN_PERIOD) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(WARN_PERIOD - 1);

    logic [PH_W-1:0] phase;

    // Count failures, track the period phase and form the warning pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
            phase   <= '0;
            warn_o  <= 1'b0;
        end else begin
            warn_o <= inc_i && (phase == PH_LAST);
            if (clr_i) begin
                count_o <= '0;
                phase   <= '0;
            end else if (inc_i) begin
                count_o <= count_o + 1'b1;
                phase   <= (phase == PH_LAST) ? '0 : phase + 1'b1;
            end
        end
    end

    // R9
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_o == '0));

    // R9
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i) |=> (count_o == $past(count_o) + CNT_W'(1)));

    // R10
    warn_follows_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warn_o |-> $past(inc_i));

endmodule

// File: rtl/resv_monitor.sv
// Load-locked / store-conditional reservation monitor for N_CTX contexts.
// Decodes one request per cycle, judges store-conditionals against the
// issuer's reservation, invalidates matching reservations on every store
// that commits, and counts consecutive failures per context.
// Assumes at most one request per cycle; outputs lag requests by one cycle.
module resv_monitor #(
    parameter int N_CTX       = 4,
    parameter int ADDR_W      = 64,
    parameter int CNT_W       = 32,
    parameter int WARN_PERIOD = 100000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [$clog2(N_CTX)-1:0]   req_ctx,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [1:0]                 req_kind,
    input  logic                       req_uncached,
    output logic                       sc_valid,
    output logic [1:0]                 sc_result,
    output logic                       mem_wr_en,
    output logic [N_CTX-1:0]           fail_warn,
    output logic [N_CTX*CNT_W-1:0]     fail_count
);

    import resv_pkg::*;

    localparam int CTX_W = $clog2(N_CTX);
    localparam int BLK_W = ADDR_W - BLK_SHIFT;

    req_kind_e          kind;
    logic               is_ll, is_st, is_sc, sc_uc, sc_pass, sc_fail, commit;
    logic [BLK_W-1:0]   req_blk;
    logic [N_CTX-1:0]   slot_valid, slot_match, slot_hit, own;

    // Decode the request and settle the store-conditional outcome.
    always_comb begin
        kind    = req_kind_e'(req_kind);
        req_blk = req_addr[ADDR_W-1:BLK_SHIFT];
        is_ll   = req_valid && (kind == REQ_LOCK_LOAD);
        is_st   = req_valid && (kind == REQ_STORE);
        is_sc   = req_valid && (kind == REQ_COND_STORE);
        sc_uc   = is_sc && req_uncached;
        sc_pass = is_sc && !req_uncached && slot_hit[req_ctx];
        sc_fail = is_sc && !req_uncached && !slot_hit[req_ctx];
        commit  = is_st || sc_uc || sc_pass;
    end

    generate
        for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
            // Mark the issuing context and its live block hit.
            always_comb begin
                own[c]      = (req_ctx == CTX_W'(c));
                slot_hit[c] = slot_valid[c] && slot_match[c];
            end

            resv_slot #(.BLK_W(BLK_W)) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_i   (is_ll && own[c]),
                .clr_i   ((commit && slot_match[c]) || (sc_fail && own[c])),
                .blk_i   (req_blk),
                .valid_o (slot_valid[c]),
                .match_o (slot_match[c])
            );

            fail_tracker #(.CNT_W(CNT_W), .WARN_PERIOD(WARN_PERIOD)) u_fail (
                .clk     (clk),
                .rst_n   (rst_n),
                .inc_i   (sc_fail && own[c]),
                .clr_i   ((sc_pass || sc_uc) && own[c]),
                .count_o (fail_count[c*CNT_W +: CNT_W]),
                .warn_o  (fail_warn[c])
            );
        end
    endgenerate

    // Register the result code and the memory write enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_valid  <= 1'b0;
            sc_result <= SC_FAIL;
            mem_wr_en <= 1'b0;
        end else begin
            sc_valid  <= is_sc;
            sc_result <= sc_uc ? SC_BYPASS : (sc_pass ? SC_PASS : SC_FAIL);
            mem_wr_en <= commit;
        end
    end

    // R4
    fail_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && sc_result == SC_FAIL) |-> !mem_wr_en);

    // R11
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid |-> (sc_result != 2'd3));

    // R8
    load_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd0) |=> (!mem_wr_en && !sc_valid));

    // R5
    bypass_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && sc_result == SC_BYPASS) |-> mem_wr_en);

    // R10
    warn_at_most_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fail_warn));

endmodule

// File: tb/tb_resv_monitor.sv
module tb_resv_monitor;

    localparam int N  = 4;
    localparam int AW = 64;
    localparam int CW = 16;
    localparam int WP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_ctx = '0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_kind = '0;
    logic          req_uncached = 1'b0;
    logic          sc_valid;
    logic [1:0]    sc_result;
    logic          mem_wr_en;
    logic [N-1:0]  fail_warn;
    logic [N*CW-1:0] fail_count;

    int checks = 0;
    int fails  = 0;
    int exp_cnt [N];

    always #4 clk = ~clk;

    resv_monitor #(.N_CTX(N), .ADDR_W(AW), .CNT_W(CW), .WARN_PERIOD(WP)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctx(req_ctx),
        .req_addr(req_addr), .req_kind(req_kind), .req_uncached(req_uncached),
        .sc_valid(sc_valid), .sc_result(sc_result), .mem_wr_en(mem_wr_en),
        .fail_warn(fail_warn), .fail_count(fail_count)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // Present one request at a falling edge; return at the next falling edge.
    task automatic drive(input int ctx, input logic [AW-1:0] a, input logic [1:0] k, input bit uc);
        req_valid = 1'b1; req_ctx = 2'(ctx); req_addr = a; req_kind = k; req_uncached = uc;
        @(negedge clk);
        req_valid = 1'b0; req_uncached = 1'b0;
    endtask

    task automatic lock_load(input int ctx, input logic [AW-1:0] a, input string tag);
        drive(ctx, a, 2'd1, 1'b0);
        chk({tag, " locked load no sc_valid"}, sc_valid, 0);
        chk({tag, " locked load no write"}, mem_wr_en, 0);
    endtask

    task automatic plain_store(input int ctx, input logic [AW-1:0] a, input string tag);
        drive(ctx, a, 2'd2, 1'b0);
        chk({tag, " store writes"}, mem_wr_en, 1);
        chk({tag, " store no sc_valid"}, sc_valid, 0);
    endtask

    // Issue a store-conditional and compare against the requirement model.
    task automatic cond_store(input int ctx, input logic [AW-1:0] a, input bit uc,
                              input logic [1:0] exp, input string tag);
        logic [N-1:0] wexp;
        wexp = '0;
        drive(ctx, a, 2'd3, uc);
        if (uc || exp == 2'd1) exp_cnt[ctx] = 0;
        else begin
            exp_cnt[ctx]++;
            if (exp_cnt[ctx] % WP == 0) wexp[ctx] = 1'b1;
        end
        chk({tag, " sc_valid"}, sc_valid, 1);
        chk({tag, " result"}, sc_result, exp);
        chk({tag, " write enable"}, mem_wr_en, (exp != 2'd0));
        chk({tag, " count R9"}, fail_count[ctx*CW +: CW], exp_cnt[ctx]);
        chk({tag, " warn R10"}, fail_warn, wexp);
    endtask

    task automatic t_reset;
        chk("R1 sc_valid in reset", sc_valid, 0);
        chk("R1 write in reset", mem_wr_en, 0);
        chk("R1 warn in reset", fail_warn, 0);
        chk("R1 counts in reset", fail_count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        cond_store(0, 64'h100, 0, 2'd0, "R1 R4 sc after reset");
    endtask

    task automatic t_pass;
        lock_load(1, 64'h1000, "R11");
        cond_store(1, 64'h100C, 0, 2'd1, "R2 R3 R11 pass same block");
        cond_store(1, 64'h1000, 0, 2'd0, "R6 pass clears own");
    endtask

    task automatic t_granule;
        lock_load(2, 64'h2008, "R3");
        cond_store(2, 64'h2010, 0, 2'd0, "R3 next block fails");
        cond_store(2, 64'h2008, 0, 2'd0, "R4 fail cleared flag");
    endtask

    task automatic t_store_clears;
        lock_load(0, 64'h3000, "R6");
        lock_load(3, 64'h3004, "R6");
        plain_store(1, 64'h300F, "R6 R11");
        cond_store(0, 64'h3000, 0, 2'd0, "R6 ctx0 cleared");
        cond_store(3, 64'h3004, 0, 2'd0, "R6 ctx3 cleared");
    endtask

    task automatic t_other_block;
        lock_load(0, 64'h4000, "R7");
        plain_store(2, 64'h4010, "R7");
        cond_store(0, 64'h4000, 0, 2'd1, "R7 reservation kept");
    endtask

    task automatic t_loads;
        lock_load(1, 64'h5000, "R8");
        drive(1, 64'h6000, 2'd0, 1'b0);
        chk("R8 load no write", mem_wr_en, 0);
        chk("R8 load no sc_valid", sc_valid, 0);
        drive(2, 64'h5000, 2'd0, 1'b0);
        chk("R8 load no write", mem_wr_en, 0);
        cond_store(1, 64'h5000, 0, 2'd1, "R8 reservation unchanged");
    endtask

    task automatic t_uncached;
        cond_store(2, 64'h7000, 1, 2'd2, "R5 bypass resets count");
        lock_load(3, 64'h7000, "R5");
        cond_store(2, 64'h7004, 1, 2'd2, "R5 bypass");
        cond_store(3, 64'h7000, 0, 2'd0, "R5 bypass invalidates");
    endtask

    task automatic t_warn;
        cond_store(0, 64'h9000, 0, 2'd0, "R10 fail 1");
        cond_store(0, 64'h9000, 0, 2'd0, "R10 fail 2");
        cond_store(0, 64'h9000, 0, 2'd0, "R10 fail 3");
        lock_load(0, 64'h8000, "R9");
        cond_store(0, 64'h8000, 0, 2'd1, "R9 pass resets");
    endtask

    task automatic t_top_bit;
        lock_load(3, 64'hFFFF_0000_0000_1230, "R3");
        cond_store(3, 64'h7FFF_0000_0000_1230, 0, 2'd0, "R3 top bit differs");
    endtask

    initial begin
        for (int i = 0; i < N; i++) exp_cnt[i] = 0;
        repeat (3) @(negedge clk);
        t_reset();
        t_pass();
        t_granule();
        t_store_clears();
        t_other_block();
        t_loads();
        t_uncached();
        t_warn();
        t_top_bit();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule